// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave side of a four-wire serial link for a small flash-style memory. While chip select is low it shifts in bytes from the serial data input on rising serial-clock edges, most significant bit first. It splits them into an opcode, a three-byte address and, where a command has one, a dummy byte. For the three commands that return data (array read, status read and identification read) it drives the serial output on falling serial-clock edges. It also decides between clock mode 0 and mode 3 from the serial-clock level seen when chip select falls.

The serial pins are synchronized into the system clock, and every edge is taken from the synchronized copies. The system clock must run at least four times faster than the serial clock. Array data comes from a one-cycle synchronous read port. Write-type commands are passed to a separate write controller as one-cycle strobes, issued when chip select rises, and only when the release lands on a whole byte. Program data bytes are streamed to the controller as they complete. The block handles the power-down state itself. The status byte and the busy flag are supplied by the write controller.

Top module: `spi_flash_frontend`

## Requirements
- R1: `mode3` takes the level of `sck` at the falling edge of `cs_n`: 0 selects clock mode 0, 1 selects clock mode 3. Both modes shift in on rising and shift out on falling edges.
- R2: Input bits are taken on rising `sck`, MSB first. The three bytes after the opcode form a 24-bit address, of which only the low 19 bits are kept, so bits 23..19 are ignored.
- R3: Opcode 03h reads array data from the address, starting on the falling edge that follows the last address bit. Opcode 0Bh does the same after one extra dummy byte. Each byte goes out MSB first, and the address then advances by one for the next byte.
- R4: The read address wraps from 7FFFFh to 00000h.
- R5: Opcode 05h puts `stat_in` on the output, repeated for every further byte while the clock runs.
- R6: Opcode 9Fh outputs the repeating byte sequence 62h, 11h, 00h. If `wr_busy` is high when the opcode completes, the output stays disabled.
- R7: On a byte-aligned rise of `cs_n`, a one-cycle `cmd_valid` is issued with `cmd_kind` and `cmd_addr`. The encoding is 06h→0 (set write enable), 04h→1 (clear write enable), DBh→2 (page erase), D8h→3 (sector erase), C7h→4 (chip erase), 02h→5 (program), 0Ah→6 (page rewrite). Erase commands DBh/D8h need at least 4 bytes, 02h/0Ah need at least 5, and the rest need 1. Other opcodes or shorter transfers produce no strobe.
- R8: If `cs_n` rises when the bit count is not a multiple of 8, no strobe is issued.
- R9: For 02h and 0Ah, each completed byte after the address gives a one-cycle `pd_valid` with that byte on `pd_data`.
- R10: A byte-aligned B9h sets `pdown`, and ABh clears it. While `pdown` is set, every other opcode gives no strobe, no data pulse and no output.
- R11: After reset, `so_oe`, `cmd_valid`, `pd_valid` and `pdown` are low. `so_oe` is low while deselected and during the opcode, address and dummy bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| mode3 | output | 1 | Detected clock mode (1 = mode 3) |
| mem_addr | output | 19 | Array read address |
| mem_rd | output | 1 | Array read request, one cycle |
| mem_rdata | input | 8 | Array data, valid the cycle after `mem_rd` |
| stat_in | input | 8 | Status byte from the write controller |
| wr_busy | input | 1 | Write controller busy |
| cmd_valid | output | 1 | Command strobe |
| cmd_kind | output | 3 | Decoded command kind |
| cmd_addr | output | 19 | Address captured for the command |
| pd_valid | output | 1 | Program data byte strobe |
| pd_data | output | 8 | Program data byte |
| pdown | output | 1 | Power-down state |

## Verification
Some properties are checked on every cycle: strobes and read requests last a single cycle, nothing leaves the block while power-down is held, and the output enable only rises with chip select low. Other behaviours only show up in the bench's scenarios. These are the bit-exact output stream for each mode, address wrap, the ID sequence and its suppression while busy, the minimum byte counts, and the rejection of a misaligned release. Each of them depends on a whole transfer.

// File: rtl/spi_fe_pkg.sv
// Shared opcodes, command kinds and output source selectors for the
// serial flash front-end.
package spi_fe_pkg;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_PERASE = 8'hDB;
    localparam logic [7:0] OP_SERASE = 8'hD8;
    localparam logic [7:0] OP_CERASE = 8'hC7;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_PWRITE = 8'h0A;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_SLEEP  = 8'hB9;
    localparam logic [7:0] OP_WAKE   = 8'hAB;
    localparam logic [7:0] OP_STAT   = 8'h05;
    localparam logic [7:0] OP_IDENT  = 8'h9F;

    typedef enum logic [2:0] {
        K_WREN   = 3'd0,
        K_WRDI   = 3'd1,
        K_PERASE = 3'd2,
        K_SERASE = 3'd3,
        K_CERASE = 3'd4,
        K_PROG   = 3'd5,
        K_PWRITE = 3'd6
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SRC_MEM  = 2'd0,
        SRC_STAT = 2'd1,
        SRC_ID   = 2'd2
    } out_src_e;
endpackage

// File: rtl/fe_sync.sv
// Multi-bit, multi-stage synchronizer. Each bit is independent; assumes
// the inputs are quasi-static relative to the stage count.
module fe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pipe[s] <= RST_VAL;
                else if (s == 0)
                    pipe[s] <= d;
                else
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/fe_byte_src.sv
// Selects the byte to be shifted out: array data, status, or the
// identification sequence at position id_idx (0..2).
module fe_byte_src
    import spi_fe_pkg::*;
(
    input  out_src_e   src,
    input  logic [7:0] mem_rdata,
    input  logic [7:0] stat_in,
    input  logic [1:0] id_idx,
    output logic [7:0] byte_out
);
    // Choose the outgoing byte from the active source.
    always_comb begin
        unique case (src)
            SRC_STAT: byte_out = stat_in;
            SRC_ID: begin
                case (id_idx)
                    2'd0:    byte_out = 8'h62;
                    2'd1:    byte_out = 8'h11;
                    default: byte_out = 8'h00;
                endcase
            end
            default:  byte_out = mem_rdata;
        endcase
    end
endmodule

// File: rtl/spi_flash_frontend.sv
// Serial flash command front-end. Shifts in opcode/address/data on rising
// SCK, shifts out read/status/ID data on falling SCK, detects clock mode
// at chip-select fall and issues write-command strobes on a byte-aligned
// chip-select rise. Assumes clk >= 4x SCK; mem_rdata valid one cycle
// after mem_rd.
module spi_flash_frontend
    import spi_fe_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic              mode3,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        stat_in,
    input  logic              wr_busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              pd_valid,
    output logic [7:0]        pd_data,
    output logic              pdown
);
    localparam int ADDR_KEEP = ADDR_W - 8;
    localparam logic [2:0] CNT_SAT = 3'd7;

    logic cs_s, sck_s, si_s, cs_q, sck_q;
    fe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q({cs_s, sck_s, si_s}));

    // Delay synchronized pins by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;
        end
    end

    logic sel, cs_fall, cs_rise, sck_rise, sck_fall;
    assign sel      = !cs_s;
    assign cs_fall  = cs_q && !cs_s;
    assign cs_rise  = !cs_q && cs_s;
    assign sck_rise = sel && !sck_q && sck_s;
    assign sck_fall = sel && sck_q && !sck_s;

    logic [2:0]        bitpos, byte_cnt, out_cnt;
    logic [6:0]        sh;
    logic [7:0]        opcode, new_byte, src_byte;
    logic [ADDR_W-1:0] addr;
    logic              out_on, byte_done;
    logic [1:0]        id_idx;
    out_src_e          src;

    assign new_byte  = {sh, si_s};
    assign byte_done = sck_rise && (bitpos == 3'd7);

    fe_byte_src u_src (
        .src(src), .mem_rdata(mem_rdata), .stat_in(stat_in),
        .id_idx(id_idx), .byte_out(src_byte));

    // Input shifting, opcode/address capture and output-phase start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitpos <= '0; byte_cnt <= '0; sh <= '0; opcode <= '0;
            addr <= '0; out_on <= 1'b0; out_cnt <= '0; id_idx <= '0;
            src <= SRC_MEM; mem_rd <= 1'b0; so <= 1'b0; mode3 <= 1'b0;
            pd_valid <= 1'b0; pd_data <= '0;
        end else begin
            mem_rd   <= 1'b0;
            pd_valid <= 1'b0;
            if (cs_fall) begin
                bitpos <= '0; byte_cnt <= '0; out_on <= 1'b0;
                out_cnt <= '0; id_idx <= '0; mode3 <= sck_s;
            end
            if (sck_rise) begin
                sh     <= new_byte[6:0];
                bitpos <= bitpos + 3'd1;
            end
            if (byte_done) begin
                if (byte_cnt != CNT_SAT) byte_cnt <= byte_cnt + 3'd1;
                if (byte_cnt == 3'd0) begin
                    opcode <= new_byte;
                    src <= (new_byte == OP_STAT)  ? SRC_STAT :
                           (new_byte == OP_IDENT) ? SRC_ID : SRC_MEM;
                    if (!pdown && (new_byte == OP_STAT ||
                                   (new_byte == OP_IDENT && !wr_busy)))
                        out_on <= 1'b1;
                end else if (byte_cnt <= 3'd3) begin
                    addr <= {addr[ADDR_KEEP-1:0], new_byte};
                end
                if (!pdown && ((byte_cnt == 3'd3 && opcode == OP_READ) ||
                               (byte_cnt == 3'd4 && opcode == OP_FREAD))) begin
                    out_on <= 1'b1;
                    mem_rd <= 1'b1;
                end
                if (!pdown && byte_cnt >= 3'd4 &&
                    (opcode == OP_PROG || opcode == OP_PWRITE)) begin
                    pd_valid <= 1'b1;
                    pd_data  <= new_byte;
                end
            end
            if (sck_fall && out_on) begin
                so      <= src_byte[3'd7 - out_cnt];
                out_cnt <= out_cnt + 3'd1;
                if (out_cnt == 3'd7) begin
                    if (src == SRC_MEM) begin
                        addr   <= addr + 1'b1;
                        mem_rd <= 1'b1;
                    end
                    if (src == SRC_ID)
                        id_idx <= (id_idx == 2'd2) ? 2'd0 : id_idx + 2'd1;
                end
            end
        end
    end

    logic       cmd_ok;
    logic [2:0] kind_n;

    // Decode the command at chip-select release and its minimum length.
    always_comb begin
        cmd_ok = 1'b0;
        kind_n = K_WREN;
        unique case (opcode)
            OP_WREN:   begin kind_n = K_WREN;   cmd_ok = byte_cnt >= 3'd1; end
            OP_WRDI:   begin kind_n = K_WRDI;   cmd_ok = byte_cnt >= 3'd1; end
            OP_CERASE: begin kind_n = K_CERASE; cmd_ok = byte_cnt >= 3'd1; end
            OP_PERASE: begin kind_n = K_PERASE; cmd_ok = byte_cnt >= 3'd4; end
            OP_SERASE: begin kind_n = K_SERASE; cmd_ok = byte_cnt >= 3'd4; end
            OP_PROG:   begin kind_n = K_PROG;   cmd_ok = byte_cnt >= 3'd5; end
            OP_PWRITE: begin kind_n = K_PWRITE; cmd_ok = byte_cnt >= 3'd5; end
            default:   cmd_ok = 1'b0;
        endcase
    end

    logic aligned;
    assign aligned = (bitpos == 3'd0) && (byte_cnt != 3'd0);

    // Issue command strobes and track power-down on chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0; cmd_kind <= '0; pdown <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (cs_rise && aligned) begin
                if (pdown) begin
                    if (opcode == OP_WAKE) pdown <= 1'b0;
                end else if (opcode == OP_SLEEP) begin
                    pdown <= 1'b1;
                end else if (cmd_ok) begin
                    cmd_valid <= 1'b1;
                    cmd_kind  <= kind_n;
                end
            end
        end
    end

    assign so_oe    = out_on && sel;
    assign mem_addr = addr;
    assign cmd_addr = addr;
endmodule

// File: rtl/spi_flash_frontend_chk.sv
// Property checker for the serial flash front-end; bound to the top.
module spi_flash_frontend_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic cmd_valid,
    input logic pd_valid,
    input logic mem_rd,
    input logic so_oe,
    input logic pdown
);
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    a_r9_data_single: assert property (@(posedge clk) disable iff (!rst_n)
        pd_valid |=> !pd_valid);
    a_r3_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    a_r10_pd_silent: assert property (@(posedge clk) disable iff (!rst_n)
        pdown |-> (!cmd_valid && !pd_valid && !so_oe));
    a_r11_oe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> !cs_n);
endmodule

bind spi_flash_frontend spi_flash_frontend_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
    .pd_valid(pd_valid), .mem_rd(mem_rd), .so_oe(so_oe), .pdown(pdown));

// File: tb/tb_spi_flash_frontend.sv
`timescale 1ns/1ps
module tb_spi_flash_frontend;
    localparam int H = 40;
    logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, wr_busy = 0;
    logic so, so_oe, mode3, mem_rd, cmd_valid, pd_valid, pdown;
    logic [18:0] mem_addr, cmd_addr;
    logic [7:0] mem_rdata = 0, stat_in = 8'hA5, pd_data;
    logic [2:0] cmd_kind;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    spi_flash_frontend dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
        .so_oe(so_oe), .mode3(mode3), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .stat_in(stat_in), .wr_busy(wr_busy),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .pd_valid(pd_valid), .pd_data(pd_data), .pdown(pdown));

    function automatic logic [7:0] fmem(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]};
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= fmem(mem_addr);

    logic seen; logic [2:0] seen_kind; logic [18:0] seen_addr;
    int pd_cnt; logic [7:0] pd_last;
    always @(posedge clk) begin
        if (cmd_valid) begin seen <= 1; seen_kind <= cmd_kind; seen_addr <= cmd_addr; end
        if (pd_valid) begin pd_cnt <= pd_cnt + 1; pd_last <= pd_data; end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        @(negedge clk); seen = 0; pd_cnt = 0;
    endtask

    task automatic start(input logic m3);
        sck = m3; #(2*H); cs_n = 0; #(H);
    endtask

    task automatic xbyte(input logic [7:0] din, output logic [7:0] dout, output logic oe);
        oe = 1;
        for (int i = 7; i >= 0; i--) begin
            sck = 0; si = din[i]; #(H);
            dout[i] = so; oe &= so_oe;
            sck = 1; #(H);
        end
    endtask

    task automatic xbits(input logic [7:0] din, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sck = 0; si = din[i]; #(H); sck = 1; #(H);
        end
    endtask

    task automatic stop(input logic m3);
        if (!m3) sck = 0;
        #(H); cs_n = 1; #(4*H);
    endtask

    task automatic send1(input logic [7:0] op);
        logic [7:0] d; logic o;
        clr(); start(0); xbyte(op, d, o); stop(0);
    endtask

    // {opcode, byte count, strobe expected, kind}
    localparam logic [15:0] VECS [10] = '{
        {8'h06, 4'd1, 1'b1, 3'd0}, {8'h04, 4'd1, 1'b1, 3'd1},
        {8'hC7, 4'd1, 1'b1, 3'd4}, {8'hDB, 4'd4, 1'b1, 3'd2},
        {8'hD8, 4'd4, 1'b1, 3'd3}, {8'h02, 4'd5, 1'b1, 3'd5},
        {8'h0A, 4'd6, 1'b1, 3'd6}, {8'hDB, 4'd3, 1'b0, 3'd0},
        {8'h03, 4'd4, 1'b0, 3'd0}, {8'h55, 4'd1, 1'b0, 3'd0}};

    initial begin
        #(1000000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d; logic o; logic [7:0] e;
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #(4*H);
        // R11: reset state
        chk(!so_oe && !cmd_valid && !pd_valid && !pdown, "R11 reset", {so_oe, cmd_valid, pdown}, 0);

        // R7 table walk
        for (int v = 0; v < 10; v++) begin
            clr(); start(0);
            xbyte(VECS[v][15:8], d, o);
            for (int b = 1; b < int'(VECS[v][7:4]); b++) xbyte(8'h10 + 8'(b), d, o);
            stop(0);
            chk(seen == VECS[v][3], "R7 strobe", seen, VECS[v][3]);
            if (VECS[v][3]) chk(seen_kind == VECS[v][2:0], "R7 kind", seen_kind, VECS[v][2:0]);
        end

        // R2 R3: read, mode 0, top address bits ignored
        clr(); start(0);
        xbyte(8'h03, d, o); chk(!o, "R11 oe in opcode", o, 0);
        xbyte(8'hF9, d, o); xbyte(8'h23, d, o); xbyte(8'h45, d, o);
        chk(!o, "R11 oe in address", o, 0);
        chk(mode3 == 0, "R1 mode0", mode3, 0);
        for (int k = 0; k < 3; k++) begin
            xbyte(8'h00, d, o);
            e = fmem(19'h12345 + 19'(k));
            chk(o && d == e, "R3 read data", d, e);
        end
        stop(0);
        chk(!so_oe, "R11 oe deselected", so_oe, 0);

        // R4: fast read across wrap, mode 3
        clr(); start(1);
        xbyte(8'h0B, d, o); xbyte(8'h07, d, o); xbyte(8'hFF, d, o); xbyte(8'hFF, d, o);
        xbyte(8'h00, d, o); chk(!o, "R3 dummy quiet", o, 0);
        chk(mode3 == 1, "R1 mode3", mode3, 1);
        xbyte(8'h00, d, o); chk(d == fmem(19'h7FFFF), "R3 fast read", d, fmem(19'h7FFFF));
        xbyte(8'h00, d, o); chk(d == fmem(19'h0), "R4 wrap", d, fmem(19'h0));
        stop(1);

        // R5: status repeats, mode 3
        clr(); start(1); xbyte(8'h05, d, o);
        for (int k = 0; k < 2; k++) begin
            xbyte(8'h00, d, o); chk(o && d == 8'hA5, "R5 status", d, 8'hA5);
        end
        stop(1);

        // R6: ID sequence and busy suppression
        clr(); start(0); xbyte(8'h9F, d, o);
        for (int k = 0; k < 4; k++) begin
            xbyte(8'h00, d, o);
            e = (k % 3 == 0) ? 8'h62 : (k % 3 == 1) ? 8'h11 : 8'h00;
            chk(o && d == e, "R6 id", d, e);
        end
        stop(0);
        wr_busy = 1;
        clr(); start(0); xbyte(8'h9F, d, o); xbyte(8'h00, d, o); stop(0);
        chk(!o, "R6 id busy", o, 0);
        wr_busy = 0;

        // R8: misaligned release
        clr(); start(0); xbyte(8'h06, d, o); xbits(8'hFF, 3); stop(0);
        chk(!seen, "R8 misaligned wren", seen, 0);
        clr(); start(0); xbyte(8'h02, d, o); xbyte(8'h01, d, o); xbyte(8'h02, d, o);
        xbyte(8'h03, d, o); xbyte(8'hC3, d, o); xbits(8'hF0, 4); stop(0);
        chk(!seen, "R8 misaligned prog", seen, 0);

        // R9: program data stream and address
        clr(); start(0); xbyte(8'h02, d, o); xbyte(8'h04, d, o); xbyte(8'h56, d, o);
        xbyte(8'h78, d, o); xbyte(8'h3C, d, o); xbyte(8'h9E, d, o); stop(0);
        chk(pd_cnt == 2, "R9 data count", pd_cnt, 2);
        chk(pd_last == 8'h9E, "R9 data byte", pd_last, 8'h9E);
        chk(seen && seen_addr == 19'h45678, "R2 cmd addr", seen_addr, 19'h45678);

        // R10: power-down
        send1(8'hB9); chk(pdown, "R10 enter", pdown, 1);
        send1(8'h06); chk(!seen, "R10 ignored wren", seen, 0);
        clr(); start(0); xbyte(8'h05, d, o); xbyte(8'h00, d, o); stop(0);
        chk(!o, "R10 ignored status", o, 0);
        send1(8'hAB); chk(!pdown, "R10 exit", pdown, 0);
        send1(8'h06); chk(seen, "R10 wren after exit", seen, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule